// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Core

This block is a single-cycle processor for a small 64-bit load/store instruction set. Each clock edge completes one instruction. In the same cycle the block fetches a 32-bit word from an internal instruction store of 1024 words, decodes it, reads two operands from a 32-entry register file, computes in an ALU, reads or writes an internal byte-addressed data memory of 1024 64-bit words, and updates the program counter. The instruction store is preloaded with a fixed program. Each instruction word is assembled from four program bytes, least significant byte first.

A two-state controller governs execution. `RUN` is entered on reset. The transition RUN→HALTED fires on the edge that executes the halt opcode. HALTED→HALTED holds until reset, and reset→RUN is the only way out. While halted, the PC, the registers and the data memory do not change. Two combinational debug ports let the surrounding logic read any register and any data-memory word at any time.

Top module: `sc64_core`

## Requirements
- R1: Asynchronous active-low reset sets the PC to 0, clears every register and puts the controller in RUN (halted low). After release, the first edge executes the word at byte address 0.
- R2: Register-format ADD (11-bit opcode 10001011000), SUB (11001011000), AND (10001010000) and ORR (10101010000) write Rd = Rn op Rm. Rd is in bits 4:0, Rn in bits 9:5 and Rm in bits 20:16. Arithmetic is 64-bit and wraps.
- R3: Add-immediate (10-bit opcode 1001000100 in bits 31:22) writes Rd = Rn + a zero-extended 12-bit immediate taken from bits 21:10. An immediate of 4095 is used without sign extension.
- R4: Load (11111000010) and store (11111000000) form the byte address as base register (bits 9:5) plus a sign-extended 9-bit offset (bits 20:12). The data-memory word index is that address divided by 8. The data register is in bits 4:0. A store commits at the clock edge. A load returns its word within the same cycle.
- R5: Register 31 reads as zero on every read port, including debug, and writes to it are discarded.
- R6: Branch-on-zero (8-bit opcode 10110100) and branch-on-nonzero (10110101) test the register in bits 4:0. When the test holds, PC becomes PC + 4 × sign-extended 19-bit offset (bits 23:5). Otherwise PC becomes PC + 4. The offset may be negative.
- R7: The unconditional branch (6-bit opcode 000101) sets PC to PC + 4 × sign-extended 26-bit offset (bits 25:0), forward or backward.
- R8: The halt opcode (11111111111) sets halted on the edge that executes it. From then on the PC, registers and data memory stay frozen and halted stays high until reset.
- R9: A word that matches no opcode changes no register and no memory word, and advances the PC by 4.
- R10: The debug ports return the selected register and data-memory word combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every instruction completes on a rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| halted | output | 1 | High while the controller is in HALTED |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_val | output | 64 | Value of the selected register (0 for register 31) |
| dbg_mem_idx | input | $clog2(DMEM_WORDS) | Data-memory word index to observe |
| dbg_mem_val | output | 64 | Contents of the selected data-memory word |

## Verification
The assertions assume that reset is asserted before the first edge that matters. They also assume the preloaded program uses load and store addresses that are multiples of 8, so that dividing by 8 loses no information. The built-in program keeps all data accesses 8-byte aligned, and it keeps every fetch inside the 1024-word store. The bench drives only clock, reset and the two debug selects, whose full ranges are legal. Taken and untaken cases of both conditional branches, a backward branch, a negative memory offset, a write to register 31 and a non-matching word all occur in the program before its halt.

// File: rtl/sc64_pkg.sv
package sc64_pkg;

    localparam int XLEN   = 64;
    localparam int REG_AW = 5;

    localparam logic [10:0] OPC_LDUR = 11'b11111000010;
    localparam logic [10:0] OPC_STUR = 11'b11111000000;
    localparam logic [10:0] OPC_ADD  = 11'b10001011000;
    localparam logic [10:0] OPC_SUB  = 11'b11001011000;
    localparam logic [10:0] OPC_AND  = 11'b10001010000;
    localparam logic [10:0] OPC_ORR  = 11'b10101010000;
    localparam logic [10:0] OPC_HALT = 11'b11111111111;
    localparam logic [9:0]  OPC_ADDI = 10'b1001000100;
    localparam logic [7:0]  OPC_CBZ  = 8'b10110100;
    localparam logic [7:0]  OPC_CBNZ = 8'b10110101;
    localparam logic [5:0]  OPC_B    = 6'b000101;

    typedef enum logic [3:0] {
        OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_ORR, OP_ADDI,
        OP_LDUR, OP_STUR, OP_CBZ, OP_CBNZ, OP_B, OP_HALT
    } op_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_e;

    typedef enum logic {ST_RUN, ST_HALTED} run_state_e;

    typedef struct packed {
        op_e               op;
        alu_e              alu;
        logic              reg_write;
        logic              mem_read;
        logic              mem_write;
        logic              use_imm;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rn;
        logic [REG_AW-1:0] rm;
        logic [XLEN-1:0]   imm;
    } ctrl_t;

    // Encoding helpers used to build the preloaded program.
    function automatic logic [31:0] enc_r(logic [10:0] opc, logic [4:0] rd,
                                          logic [4:0] rn, logic [4:0] rm);
        return {opc, rm, 6'd0, rn, rd};
    endfunction

    function automatic logic [31:0] enc_addi(logic [4:0] rd, logic [4:0] rn,
                                             logic [11:0] imm);
        return {OPC_ADDI, imm, rn, rd};
    endfunction

    function automatic logic [31:0] enc_mem(logic [10:0] opc, logic [4:0] rt,
                                            logic [4:0] rn, logic signed [31:0] off);
        return {opc, off[8:0], 2'b00, rn, rt};
    endfunction

    function automatic logic [31:0] enc_cb(logic [7:0] opc, logic [4:0] rt,
                                           logic signed [31:0] off);
        return {opc, off[18:0], rt};
    endfunction

    function automatic logic [31:0] enc_b(logic signed [31:0] off);
        return {OPC_B, off[25:0]};
    endfunction

    // Preloaded program; unlisted words are zero, which decodes as a no-op.
    function automatic logic [31:0] prog_word(int idx);
        logic [31:0] w;
        unique case (idx)
            0:  w = enc_addi(5'd1, 5'd31, 12'd5);
            1:  w = enc_addi(5'd2, 5'd31, 12'd12);
            2:  w = enc_r(OPC_ADD, 5'd3, 5'd1, 5'd2);
            3:  w = enc_r(OPC_SUB, 5'd4, 5'd1, 5'd2);
            4:  w = enc_r(OPC_AND, 5'd5, 5'd1, 5'd2);
            5:  w = enc_r(OPC_ORR, 5'd6, 5'd1, 5'd2);
            6:  w = enc_mem(OPC_STUR, 5'd3, 5'd2, -4);
            7:  w = enc_mem(OPC_STUR, 5'd4, 5'd31, 16);
            8:  w = enc_mem(OPC_LDUR, 5'd7, 5'd1, 3);
            9:  w = enc_mem(OPC_LDUR, 5'd8, 5'd2, 4);
            10: w = enc_r(OPC_ADD, 5'd31, 5'd1, 5'd1);
            11: w = 32'h0000_0000;
            12: w = enc_cb(OPC_CBZ, 5'd1, 3);
            13: w = enc_cb(OPC_CBNZ, 5'd31, 3);
            14: w = enc_cb(OPC_CBNZ, 5'd1, 2);
            15: w = enc_addi(5'd9, 5'd31, 12'd1);
            16: w = enc_cb(OPC_CBZ, 5'd31, 2);
            17: w = enc_addi(5'd10, 5'd31, 12'd1);
            18: w = enc_b(3);
            19: w = enc_addi(5'd11, 5'd31, 12'd1);
            20: w = enc_b(4);
            21: w = enc_addi(5'd12, 5'd12, 12'd1);
            22: w = enc_addi(5'd13, 5'd31, 12'd4095);
            23: w = enc_b(-3);
            24: w = enc_addi(5'd16, 5'd31, 12'd1);
            25: w = enc_addi(5'd15, 5'd31, 12'd3);
            26: w = enc_r(OPC_SUB, 5'd15, 5'd15, 5'd16);
            27: w = enc_r(OPC_ADD, 5'd17, 5'd17, 5'd1);
            28: w = enc_cb(OPC_CBNZ, 5'd15, -2);
            29: w = {OPC_HALT, 21'd0};
            30: w = enc_addi(5'd18, 5'd31, 12'd7);
            default: w = 32'h0000_0000;
        endcase
        return w;
    endfunction

    // Byte image of a word, least significant byte first.
    function automatic logic [7:0] prog_byte(int addr);
        logic [31:0] w;
        w = prog_word(addr / 4);
        return w[8*(addr % 4) +: 8];
    endfunction

endpackage

// File: rtl/sc64_decode.sv
module sc64_decode
    import sc64_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);
    logic [10:0] opc11;
    logic [9:0]  opc10;
    logic [7:0]  opc8;
    logic [5:0]  opc6;

    assign opc11 = instr[31:21];
    assign opc10 = instr[31:22];
    assign opc8  = instr[31:24];
    assign opc6  = instr[31:26];

    always_comb begin
        ctrl           = '0;
        ctrl.op        = OP_NOP;
        ctrl.alu       = ALU_ADD;
        ctrl.rd        = instr[4:0];
        ctrl.rn        = instr[9:5];
        ctrl.rm        = instr[20:16];
        if (opc11 == OPC_ADD || opc11 == OPC_SUB ||
            opc11 == OPC_AND || opc11 == OPC_ORR) begin
            ctrl.reg_write = 1'b1;
            unique case (opc11)
                OPC_ADD: begin ctrl.op = OP_ADD; ctrl.alu = ALU_ADD; end
                OPC_SUB: begin ctrl.op = OP_SUB; ctrl.alu = ALU_SUB; end
                OPC_AND: begin ctrl.op = OP_AND; ctrl.alu = ALU_AND; end
                default: begin ctrl.op = OP_ORR; ctrl.alu = ALU_OR;  end
            endcase
        end else if (opc11 == OPC_LDUR) begin
            ctrl.op        = OP_LDUR;
            ctrl.reg_write = 1'b1;
            ctrl.mem_read  = 1'b1;
            ctrl.use_imm   = 1'b1;
            ctrl.imm       = {{(XLEN-9){instr[20]}}, instr[20:12]};
        end else if (opc11 == OPC_STUR) begin
            ctrl.op        = OP_STUR;
            ctrl.mem_write = 1'b1;
            ctrl.use_imm   = 1'b1;
            ctrl.rm        = instr[4:0];
            ctrl.imm       = {{(XLEN-9){instr[20]}}, instr[20:12]};
        end else if (opc11 == OPC_HALT) begin
            ctrl.op        = OP_HALT;
        end else if (opc10 == OPC_ADDI) begin
            ctrl.op        = OP_ADDI;
            ctrl.reg_write = 1'b1;
            ctrl.use_imm   = 1'b1;
            ctrl.imm       = {{(XLEN-12){1'b0}}, instr[21:10]};
        end else if (opc8 == OPC_CBZ || opc8 == OPC_CBNZ) begin
            ctrl.op        = (opc8 == OPC_CBZ) ? OP_CBZ : OP_CBNZ;
            ctrl.rm        = instr[4:0];
            ctrl.imm       = {{(XLEN-19){instr[23]}}, instr[23:5]};
        end else if (opc6 == OPC_B) begin
            ctrl.op        = OP_B;
            ctrl.imm       = {{(XLEN-26){instr[25]}}, instr[25:0]};
        end
    end

    // R4: a store never also writes the register file or reads memory
    always_comb begin
        assert_store_exclusive_R4: assert (!(ctrl.mem_write && (ctrl.reg_write || ctrl.mem_read)));
    end

endmodule

// File: rtl/sc64_regfile.sv
module sc64_regfile
    import sc64_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] ra1,
    input  logic [REG_AW-1:0] ra2,
    output logic [XLEN-1:0]   rd1,
    output logic [XLEN-1:0]   rd2,
    input  logic              we,
    input  logic [REG_AW-1:0] wa,
    input  logic [XLEN-1:0]   wd,
    input  logic [REG_AW-1:0] dbg_sel,
    output logic [XLEN-1:0]   dbg_val
);
    localparam int NREGS = 1 << REG_AW;
    localparam logic [REG_AW-1:0] ZREG = REG_AW'(NREGS - 1);

    logic [XLEN-1:0] regs_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we && wa != ZREG) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1     = (ra1 == ZREG)     ? '0 : regs_q[ra1];
    assign rd2     = (ra2 == ZREG)     ? '0 : regs_q[ra2];
    assign dbg_val = (dbg_sel == ZREG) ? '0 : regs_q[dbg_sel];

    // R2: a write to a real register is visible on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != ZREG) |=> (regs_q[$past(wa)] == $past(wd)));

    // R5: the zero register's storage slot is never written
    assert_zero_reg_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == ZREG) |=> $stable(regs_q[ZREG]));

endmodule

// File: rtl/sc64_alu.sv
module sc64_alu
    import sc64_pkg::*;
(
    input  alu_e            fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb begin
        unique case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/sc64_nextpc.sv
module sc64_nextpc
    import sc64_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  op_e             op,
    input  logic [XLEN-1:0] test_val,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] next_pc,
    output logic            taken
);
    always_comb begin
        unique case (op)
            OP_CBZ:  taken = (test_val == '0);
            OP_CBNZ: taken = (test_val != '0);
            OP_B:    taken = 1'b1;
            default: taken = 1'b0;
        endcase
        next_pc = taken ? (pc + (offset << 2)) : (pc + XLEN'(4));
    end
endmodule

// File: rtl/sc64_core.sv
module sc64_core
    import sc64_pkg::*;
#(
    parameter int IMEM_WORDS = 1024,
    parameter int DMEM_WORDS = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          halted,
    input  logic [REG_AW-1:0]             dbg_reg_sel,
    output logic [XLEN-1:0]               dbg_reg_val,
    input  logic [$clog2(DMEM_WORDS)-1:0] dbg_mem_idx,
    output logic [XLEN-1:0]               dbg_mem_val
);
    localparam int IMEM_AW = $clog2(IMEM_WORDS);
    localparam int DMEM_AW = $clog2(DMEM_WORDS);

    run_state_e      state_q, state_d;
    logic [XLEN-1:0] pc_q;
    logic [31:0]     instr;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, wb_data, ld_data, next_pc;
    logic            taken, running, rf_we, dm_we;
    logic [DMEM_AW-1:0] dm_idx;

    logic [31:0]     imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    // Instruction store built from the little-endian byte image.
    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) begin
            imem[i] = {prog_byte(4*i+3), prog_byte(4*i+2),
                       prog_byte(4*i+1), prog_byte(4*i)};
        end
        for (int i = 0; i < DMEM_WORDS; i++) dmem[i] = '0;
    end

    assign instr = imem[pc_q[IMEM_AW+1:2]];

    sc64_decode u_dec (.instr(instr), .ctrl(ctrl));

    sc64_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra1(ctrl.rn), .ra2(ctrl.rm), .rd1(rd1), .rd2(rd2),
        .we(rf_we), .wa(ctrl.rd), .wd(wb_data),
        .dbg_sel(dbg_reg_sel), .dbg_val(dbg_reg_val)
    );

    assign alu_b = ctrl.use_imm ? ctrl.imm : rd2;

    sc64_alu u_alu (.fn(ctrl.alu), .a(rd1), .b(alu_b), .y(alu_y));

    sc64_nextpc u_npc (
        .pc(pc_q), .op(ctrl.op), .test_val(rd2), .offset(ctrl.imm),
        .next_pc(next_pc), .taken(taken)
    );

    assign dm_idx  = alu_y[DMEM_AW+2:3];
    assign ld_data = dmem[dm_idx];
    assign wb_data = ctrl.mem_read ? ld_data : alu_y;
    assign running = (state_q == ST_RUN);
    assign rf_we   = running && ctrl.reg_write;
    assign dm_we   = running && ctrl.mem_write;
    assign dbg_mem_val = dmem[dbg_mem_idx];

    always_ff @(posedge clk) begin
        if (dm_we) dmem[dm_idx] <= rd2;
    end

    // Controller: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (ctrl.op == OP_HALT) state_d = ST_HALTED;
            ST_HALTED: state_d = ST_HALTED;
            default:   state_d = ST_RUN;
        endcase
    end

    // Controller: state and PC registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (running && ctrl.op != OP_HALT) pc_q <= next_pc;
        end
    end

    // Controller: outputs
    always_comb begin
        halted = (state_q == ST_HALTED);
    end

    logic unused_bits;
    assign unused_bits = ^{pc_q[XLEN-1:IMEM_AW+2], pc_q[1:0],
                           alu_y[XLEN-1:DMEM_AW+3], alu_y[2:0]};

    // R8: halted is sticky until reset
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8: PC frozen while halted
    assert_pc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_q));

    // R8: halted only rises after the halt opcode was executed
    assert_halt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(ctrl.op == OP_HALT));

    // R8: no store lands while halted
    assert_no_store_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dm_we);

    // R9: without a taken branch or halt, the PC advances by one word
    assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !taken && ctrl.op != OP_HALT) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    // R4: a store commits its data at the edge
    assert_store_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |=> (dmem[$past(dm_idx)] == $past(rd2)));

endmodule

// File: tb/tb_sc64_core.sv
module tb_sc64_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] M7 = 64'hFFFF_FFFF_FFFF_FFF9;

    typedef struct packed {
        logic        is_mem;
        logic [9:0]  idx;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Final architectural state expected after the program halts.
    localparam vec_t VECS [22] = '{
        '{1'b0, 10'd1,  64'd5,    4'd3},   // R3 add-immediate
        '{1'b0, 10'd2,  64'd12,   4'd3},   // R3
        '{1'b0, 10'd13, 64'd4095, 4'd3},   // R3 max immediate, zero-extended
        '{1'b0, 10'd3,  64'd17,   4'd2},   // R2 ADD
        '{1'b0, 10'd4,  M7,       4'd2},   // R2 SUB wraps negative
        '{1'b0, 10'd5,  64'd4,    4'd2},   // R2 AND
        '{1'b0, 10'd6,  64'd13,   4'd2},   // R2 ORR
        '{1'b1, 10'd1,  64'd17,   4'd4},   // R4 store with negative offset
        '{1'b1, 10'd2,  M7,       4'd4},   // R4 store base zero register
        '{1'b1, 10'd0,  64'd0,    4'd4},   // R4 untouched word
        '{1'b0, 10'd7,  64'd17,   4'd4},   // R4 load, address /8
        '{1'b0, 10'd8,  M7,       4'd4},   // R4
        '{1'b0, 10'd31, 64'd0,    4'd5},   // R5 write to X31 discarded
        '{1'b0, 10'd0,  64'd0,    4'd9},   // R9 zero word is a no-op
        '{1'b0, 10'd9,  64'd0,    4'd6},   // R6 CBNZ taken skipped it
        '{1'b0, 10'd10, 64'd0,    4'd6},   // R6 CBZ on X31 taken
        '{1'b0, 10'd17, 64'd15,   4'd6},   // R6 backward CBNZ loop x3
        '{1'b0, 10'd15, 64'd0,    4'd6},   // R6
        '{1'b0, 10'd16, 64'd1,    4'd6},   // R6
        '{1'b0, 10'd11, 64'd0,    4'd7},   // R7 B skipped it
        '{1'b0, 10'd12, 64'd1,    4'd7},   // R7 backward B, body once
        '{1'b0, 10'd18, 64'd0,    4'd8}    // R8 word after halt not run
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halted;
    logic [4:0]  dbg_reg_sel = '0;
    logic [63:0] dbg_reg_val;
    logic [9:0]  dbg_mem_idx = '0;
    logic [63:0] dbg_mem_val;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    sc64_core dut (
        .clk(clk), .rst_n(rst_n), .halted(halted),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
        .dbg_mem_idx(dbg_mem_idx), .dbg_mem_val(dbg_mem_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd_reg(input int r, output logic [63:0] v);
        dbg_reg_sel = 5'(r);
        #1;
        v = dbg_reg_val;
    endtask

    task automatic rd_mem(input int m, output logic [63:0] v);
        dbg_mem_idx = 10'(m);
        #1;
        v = dbg_mem_val;
    endtask

    task automatic walk_table(input string tag);
        logic [63:0] v;
        foreach (VECS[i]) begin
            if (VECS[i].is_mem) rd_mem(int'(VECS[i].idx), v);
            else                rd_reg(int'(VECS[i].idx), v);
            chk($sformatf("R%0d", VECS[i].req),
                $sformatf("%s %s[%0d]", tag, VECS[i].is_mem ? "mem" : "reg", VECS[i].idx),
                v, VECS[i].exp);
        end
    endtask

    initial begin
        logic [63:0] v;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "halted in reset", 64'(halted), 64'd0);
        rd_reg(1, v); chk("R1", "X1 in reset", v, 64'd0);

        // R8: halt happens on the 33rd executed instruction
        rst_n = 1'b1;
        repeat (32) @(posedge clk);
        @(negedge clk);
        chk("R8", "halted before halt edge", 64'(halted), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R8", "halted after halt edge", 64'(halted), 64'd1);

        walk_table("final");

        // R10: debug read follows the select with no clock edge
        @(negedge clk);
        dbg_reg_sel = 5'd1; #1; v = dbg_reg_val;
        dbg_reg_sel = 5'd2; #1;
        chk("R10", "combinational debug read", dbg_reg_val, 64'd12);
        chk("R10", "previous select value", v, 64'd5);

        // R8: state frozen after halt
        repeat (25) @(posedge clk);
        @(negedge clk);
        chk("R8", "halted still high", 64'(halted), 64'd1);
        walk_table("frozen");

        // R1: reset in the halted state restarts from address 0
        rst_n = 1'b0;
        #1;
        chk("R1", "halted cleared by reset", 64'(halted), 64'd0);
        rd_reg(17, v); chk("R1", "X17 cleared by reset", v, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        rd_reg(3, v); chk("R1", "X3 after 10 edges", v, 64'd17);
        rd_reg(8, v); chk("R1", "X8 after 10 edges", v, M7);
        rd_reg(9, v); chk("R1", "X9 after 10 edges", v, 64'd0);
        chk("R1", "running after restart", 64'(halted), 64'd0);
        repeat (23) @(posedge clk);
        @(negedge clk);
        chk("R8", "second run halts on time", 64'(halted), 64'd1);
        rd_reg(17, v); chk("R6", "second run loop sum", v, 64'd15);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule